// File: doc/BRIEF.md
# Microsecond Timing Synchronization Counter

This block keeps a free-running 64-bit time base that advances by one every microsecond, derived from the system clock by a parameterized cycle divider. Software reads the time through two 32-bit read ports and sets it through two 32-bit staging registers, one for the lower word and one for the upper word.

Writing a staging register never touches the running count by itself. Bit 31 of the upper staging register is a load control. The count is replaced by the staged value only when that bit goes from 1 to 0. Software therefore writes both halves, then sets the control bit, then clears it. The upper half of the loaded value has 31 writable bits, and bit 63 of the count is always loaded as zero.

Reading is kept coherent by a snapshot. Pulsing the low-read strobe captures the upper half of the count in the same cycle as the low half is sampled. A low-then-high read sequence therefore returns one consistent 64-bit time, even across a carry out of the low word.

Top module: `tsf_timer`

## Requirements
- R1: After reset the count, both staging registers and the upper-half snapshot are zero, so both read ports show 0.
- R2: The count rises by exactly 1 once every CLKS_PER_US clock cycles and holds its value in every other cycle.
- R3: A write to the low staging register (lowWrEn) never changes the running count.
- R4: A load happens only on a 1-to-0 transition of staged high bit 31, which is written through highWrData[31]. Writing 0 to that bit when it already holds 0, or writing 1 to it, loads nothing.
- R5: A load sets the count to {1'b0, staged high bits 30..0, staged low 32 bits}. The count shows this value one cycle after the cycle in which the falling control bit is registered. Bit 63 of the loaded value is always 0.
- R6: A load restarts the microsecond divider, so the first increment after a load comes exactly CLKS_PER_US cycles after the load.
- R7: When a load and a divider tick fall in the same cycle, the load wins and the tick is dropped.
- R8: lowRdData always shows the live count bits 31..0.
- R9: highRdData shows count bits 63..32 as captured in the last cycle with lowRdEn high, and it holds that value until the next such cycle.
- R10: The carry from count bits 31..0 propagates into bits 63..32 (0x5_FFFFFFFF becomes 0x6_00000000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| lowWrEn | input | 1 | Write strobe for the low staging register |
| lowWrData | input | 32 | Data for the low staging register |
| highWrEn | input | 1 | Write strobe for the high staging register |
| highWrData | input | 32 | Bits 30..0: staged upper time; bit 31: load control |
| lowRdEn | input | 1 | Low-half read strobe; captures the upper half into the snapshot |
| lowRdData | output | 32 | Live count bits 31..0 |
| highRdData | output | 32 | Snapshot of count bits 63..32 |

## Verification
Counting is observed cycle by cycle from a loaded base value. This shows that the divider period is exact and that the value holds between ticks. Load sequences are tried in three forms: a clean 1-then-0 sequence, a lone 0 write, and a lone 1 write. Together they tell a falling-edge load apart from a level-triggered or strobe-triggered one. A value with bit 31 of the upper word set shows that bit 63 is forced to zero. Reloads are placed both in the middle of a divider period and exactly on a tick, which separates the divider restart from the load-over-tick priority. A load just below a low-word wrap, with reads on both sides of the carry, exposes the carry into the upper half and shows that the snapshot holds its value until the next low read.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  typedef struct packed {
    logic load;
    logic tick;
  } tsfStrobe_t;
endpackage

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
  import tsf_pkg::*;
#(
  parameter int CLKS_PER_US = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lowWrEn,
  input  logic [31:0] lowWrData,
  input  logic        highWrEn,
  input  logic [31:0] highWrData,
  output tsfStrobe_t  strobe,
  output logic [62:0] stagedVal
);
  localparam int DIV_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_US - 1);

  logic [31:0] stageLow;
  logic [31:0] stageHigh;
  logic        ctlPrev;
  logic        loadNow;
  logic        tickNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageLow  <= '0;
      stageHigh <= '0;
      ctlPrev   <= 1'b0;
    end else begin
      if (lowWrEn)  stageLow  <= lowWrData;
      if (highWrEn) stageHigh <= highWrData;
      ctlPrev <= stageHigh[31];
    end
  end

  assign loadNow = ctlPrev & ~stageHigh[31];

  generate
    if (CLKS_PER_US > 1) begin : g_div
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN)                 divCnt <= '0;
        else if (loadNow)          divCnt <= '0;
        else if (divCnt == DIV_LAST) divCnt <= '0;
        else                       divCnt <= divCnt + 1'b1;
      end
      assign tickNow = (divCnt == DIV_LAST);
    end else begin : g_nodiv
      assign tickNow = 1'b1;
    end
  endgenerate

  always_comb begin
    strobe.load = loadNow;
    strobe.tick = tickNow & ~loadNow;
  end

  assign stagedVal = {stageHigh[30:0], stageLow};
endmodule

// File: rtl/tsf_datapath.sv
module tsf_datapath
  import tsf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  tsfStrobe_t  strobe,
  input  logic [62:0] stagedVal,
  input  logic        lowRdEn,
  output logic [63:0] tsfNow,
  output logic [31:0] highSnap
);
  always_ff @(posedge clk) begin
    if (!rstN)            tsfNow <= '0;
    else if (strobe.load) tsfNow <= {1'b0, stagedVal};
    else if (strobe.tick) tsfNow <= tsfNow + 64'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        highSnap <= '0;
    else if (lowRdEn) highSnap <= tsfNow[63:32];
  end
endmodule

// File: rtl/tsf_timer.sv
module tsf_timer
  import tsf_pkg::*;
#(
  parameter int CLKS_PER_US = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lowWrEn,
  input  logic [31:0] lowWrData,
  input  logic        highWrEn,
  input  logic [31:0] highWrData,
  input  logic        lowRdEn,
  output logic [31:0] lowRdData,
  output logic [31:0] highRdData
);
  tsfStrobe_t  strobe;
  logic [62:0] stagedVal;
  logic [63:0] tsfNow;

  tsf_ctrl #(.CLKS_PER_US(CLKS_PER_US)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lowWrEn(lowWrEn), .lowWrData(lowWrData),
    .highWrEn(highWrEn), .highWrData(highWrData),
    .strobe(strobe), .stagedVal(stagedVal)
  );

  tsf_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .stagedVal(stagedVal),
    .lowRdEn(lowRdEn),
    .tsfNow(tsfNow), .highSnap(highRdData)
  );

  assign lowRdData = tsfNow[31:0];
endmodule

// File: rtl/tsf_timer_chk.sv
module tsf_timer_chk
  import tsf_pkg::*;
#(
  parameter int CLKS_PER_US = 100
) (
  input logic        clk,
  input logic        rstN,
  input logic        lowWrEn,
  input logic        highWrEn,
  input logic [31:0] highWrData,
  input logic        lowRdEn,
  input logic [31:0] highRdData,
  input tsfStrobe_t  strobe,
  input logic [62:0] stagedVal,
  input logic [63:0] tsfNow
);
  a_r2_tick_adds_one: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.load) |=> tsfNow == $past(tsfNow) + 64'd1);

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.load) |=> $stable(tsfNow));

  a_r3_low_write_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    (lowWrEn && !strobe.load && !strobe.tick) |=> $stable(tsfNow));

  a_r4_load_needs_clear_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> $past(highWrEn && !highWrData[31]));

  a_r5_load_value: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> tsfNow == {1'b0, $past(stagedVal)});

  a_r6_divider_restart: assert property (@(posedge clk) disable iff (!rstN)
    (CLKS_PER_US > 1 && strobe.load) |=> !strobe.tick);

  a_r9_snapshot: assert property (@(posedge clk) disable iff (!rstN)
    lowRdEn |=> highRdData == $past(tsfNow[63:32]));

  a_r9_snapshot_hold: assert property (@(posedge clk) disable iff (!rstN)
    !lowRdEn |=> $stable(highRdData));
endmodule

bind tsf_timer tsf_timer_chk #(.CLKS_PER_US(CLKS_PER_US)) u_chk (
  .clk(clk), .rstN(rstN),
  .lowWrEn(lowWrEn), .highWrEn(highWrEn), .highWrData(highWrData),
  .lowRdEn(lowRdEn), .highRdData(highRdData),
  .strobe(strobe), .stagedVal(stagedVal), .tsfNow(tsfNow)
);

// File: tb/tsf_timer_bench.sv
module tsf_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lowWrEn = 1'b0;
  logic [31:0] lowWrData = '0;
  logic        highWrEn = 1'b0;
  logic [31:0] highWrData = '0;
  logic        lowRdEn = 1'b0;
  logic [31:0] lowRdData;
  logic [31:0] highRdData;

  int nChecks = 0;
  int nFail = 0;
  bit doneFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsf_timer #(.CLKS_PER_US(DIV)) u_tsf_timer (
    .clk(clk), .rstN(rstN),
    .lowWrEn(lowWrEn), .lowWrData(lowWrData),
    .highWrEn(highWrEn), .highWrData(highWrData),
    .lowRdEn(lowRdEn), .lowRdData(lowRdData), .highRdData(highRdData)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge; each write spans one rising edge.
  task automatic wrLow(input logic [31:0] d);
    lowWrEn = 1'b1; lowWrData = d;
    @(negedge clk); lowWrEn = 1'b0;
  endtask

  task automatic wrHigh(input logic [31:0] d);
    highWrEn = 1'b1; highWrData = d;
    @(negedge clk); highWrEn = 1'b0;
  endtask

  task automatic loadVal(input logic [63:0] v);
    wrLow(v[31:0]);
    wrHigh({1'b1, v[62:32]});
    wrHigh({1'b0, v[62:32]});
    @(negedge clk);
  endtask

  task automatic readPair(input string req, input logic [63:0] exp);
    lowRdEn = 1'b1;
    check(req, lowRdData, exp[31:0]);
    @(negedge clk); lowRdEn = 1'b0;
    check(req, highRdData, exp[63:32]);
  endtask

  task automatic t_reset();
    check("R1 low", lowRdData, 32'h0);
    check("R1 high", highRdData, 32'h0);
  endtask

  task automatic t_count();
    loadVal(64'h100);
    for (int k = 0; k < 12; k++) begin
      check("R2/R8 count", lowRdData, 32'h100 + 32'(k / DIV));
      @(negedge clk);
    end
  endtask

  task automatic t_lowOnly();
    loadVal(64'h2000);
    wrLow(32'hDEAD_BEEF);
    check("R3 after low write", lowRdData, 32'h2000);
    repeat (3) @(negedge clk);
    check("R3 keeps counting", lowRdData, 32'h2001);
  endtask

  task automatic t_noFall();
    loadVal(64'h3000);
    wrHigh(32'h0000_0005);
    wrHigh(32'h8000_0007);
    readPair("R4 no load", 64'h3000);
  endtask

  task automatic t_loadVal();
    loadVal(64'hFFFF_1234_5678_9ABC);
    readPair("R5 loaded value", 64'h7FFF_1234_5678_9ABC);
  endtask

  task automatic t_restart();
    loadVal(64'h4000);
    repeat (2) @(negedge clk);
    loadVal(64'h5000);
    repeat (3) @(negedge clk);
    check("R6 no early tick", lowRdData, 32'h5000);
    @(negedge clk);
    check("R6 tick after period", lowRdData, 32'h5001);
  endtask

  task automatic t_priority();
    loadVal(64'h6000);
    loadVal(64'h7000);
    check("R7 load beats tick", lowRdData, 32'h7000);
    repeat (3) @(negedge clk);
    check("R7 period after", lowRdData, 32'h7000);
    @(negedge clk);
    check("R7 first tick", lowRdData, 32'h7001);
  endtask

  task automatic t_wrap();
    loadVal(64'h5_FFFF_FFFE);
    readPair("R9 before wrap", 64'h5_FFFF_FFFE);
    repeat (7) @(negedge clk);
    check("R10 low wrapped", lowRdData, 32'h0);
    check("R9 snapshot held", highRdData, 32'h5);
    readPair("R10 carry", 64'h6_0000_0000);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_count();
    t_lowOnly();
    t_noFall();
    t_loadVal();
    t_restart();
    t_priority();
    t_wrap();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end
endmodule